// File: doc/BRIEF.md
# Radio Transmit Enable Sequencer

This block drives three staged enable strobes, T1, T2 and T3, toward a radio front end around each transmitted frame. A start request raises them in the order T1, T2, T3. An end-of-frame indication lowers them in the reverse order: T3 first, then T2, then T1. Four 4-bit gap fields set the spacing between successive edges: two for the rising edges and two for the falling edges. Gaps are counted in units of a prescaled clock. One unit is 20 or 40 input clocks, chosen by a select input. At a 20 MHz input clock with the short unit, one unit is 1 µs.

An optional clear-to-send gate can hold off the whole sequence after a start request until an external line goes high. A busy flag covers the whole sequence, from the accepted request to the fall of T1. Other logic drives the gap fields, the prescale select and the gate enable, and holds them steady while a gap is running.

Top module: `tx_ramp_seq`

## Requirements
- R1: After reset, t1_o, t2_o, t3_o and busy_o are all low.
- R2: In the idle state, a start request sampled high at a clock edge raises t1_o at that edge, provided the CTS gate is open. t2_o rises gap_up12_i units after t1_o, and t3_o rises gap_up23_i units after t2_o. Each gap field is read at the edge that begins its gap.
- R3: With all strobes high, an end-of-frame sampled high lowers t3_o at that edge. t2_o falls gap_dn32_i units later, and t1_o falls gap_dn21_i units after t2_o.
- R4: One gap unit is 20 clock cycles when presc_sel_i is 0 and 40 clock cycles when it is 1. The unit counter restarts at every strobe edge, so a gap of N units is exactly N units long.
- R5: A gap field of zero makes the two strobe edges it separates happen at the same clock edge.
- R6: When cts_en_i is 1, an accepted start request waits until cts_i is sampled high. t1_o rises at the first edge where cts_i is high, and the later edges keep their normal spacing.
- R7: When cts_en_i is 0, the level of cts_i has no effect, and t1_o rises at the edge that samples the start request.
- R8: A start request that arrives while busy_o is high is ignored. It changes no strobe timing, and no new sequence follows the end of the current one.
- R9: busy_o rises at the edge that accepts a start request, including while the CTS gate holds the sequence. It falls at the same edge as t1_o.
- R10: An end-of-frame that arrives during the CTS wait or the ramp-up is remembered. Ramp-up completes, and t3_o then falls one clock after it rose. An end-of-frame while idle is ignored.
- R11: At every cycle, t3_o high implies t2_o high, and t2_o high implies t1_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transmit start request |
| eof_i | input | 1 | End-of-frame, begins ramp-down |
| cts_en_i | input | 1 | Enables the clear-to-send gate |
| cts_i | input | 1 | External clear-to-send level |
| presc_sel_i | input | 1 | Unit select: 0 = 20 clocks, 1 = 40 clocks |
| gap_up12_i | input | 4 | Units from T1 rise to T2 rise |
| gap_up23_i | input | 4 | Units from T2 rise to T3 rise |
| gap_dn32_i | input | 4 | Units from T3 fall to T2 fall |
| gap_dn21_i | input | 4 | Units from T2 fall to T1 fall |
| t1_o | output | 1 | First strobe, outermost |
| t2_o | output | 1 | Second strobe |
| t3_o | output | 1 | Third strobe, innermost |
| busy_o | output | 1 | Sequence in progress |

## Verification
Every strobe output is registered. A start request or end-of-frame sampled at edge k therefore shows on its strobe right after edge k. Each later edge is due exactly gap × unit cycles after the edge before it. If a remembered end-of-frame arrived during ramp-up, T3 falls one cycle after it rose.

The bench numbers the clock edges from the edge that samples the start request. It computes every expected rise and fall edge from the gap fields, the unit size and the CTS release edge. It samples all outputs on the falling clock edge and records the edge at which each strobe changes, so every result is compared against the exact cycle it is due. It also checks busy_o at every sample until several cycles after T1 falls.

// File: rtl/tx_ramp_pkg.sv
package tx_ramp_pkg;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_CTS  = 3'd1,
        RS_UP2  = 3'd2,
        RS_UP3  = 3'd3,
        RS_ON   = 3'd4,
        RS_DN2  = 3'd5,
        RS_DN1  = 3'd6
    } ramp_state_e;

    typedef struct packed {
        ramp_state_e state;
        logic [2:0]  strb;
        logic        pend;
    } ramp_reg_t;

    localparam int unsigned NUM_STRB = 3;

endpackage

// File: rtl/tx_ramp_prescaler.sv
module tx_ramp_prescaler #(
    parameter int unsigned DIV_LO = 20,
    parameter int unsigned DIV_HI = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = $clog2(DIV_HI);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim    = sel_i ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
        tick_o = (cnt_q >= lim);
        if (restart_i || tick_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(DIV_HI));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/tx_ramp_gapcnt.sv
module tx_ramp_gapcnt #(
    parameter int unsigned GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GAP_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [GAP_W-1:0] units_d, units_q;

    always_comb begin
        expire_o = tick_i && (units_q == GAP_W'(1));
        if (load_i)                         units_d = load_val_i;
        else if (tick_i && units_q != '0)   units_d = units_q - 1'b1;
        else                                units_d = units_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) units_q <= '0;
        else        units_q <= units_d;
    end

    // R2
    load_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (units_q == $past(load_val_i)));

endmodule

// File: rtl/tx_ramp_fsm.sv
module tx_ramp_fsm
    import tx_ramp_pkg::*;
#(
    parameter int unsigned GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             eof_i,
    input  logic             cts_en_i,
    input  logic             cts_i,
    input  logic [GAP_W-1:0] gap_up12_i,
    input  logic [GAP_W-1:0] gap_up23_i,
    input  logic [GAP_W-1:0] gap_dn32_i,
    input  logic [GAP_W-1:0] gap_dn21_i,
    input  logic             expire_i,
    output logic [NUM_STRB-1:0] strb_o,
    output logic             busy_o,
    output logic             fire_o,
    output logic [GAP_W-1:0] load_val_o
);
    ramp_reg_t cur_q, nx_d;

    logic             adv;
    logic             gate_open;
    logic             eof_any;
    logic [GAP_W-1:0] gap;

    always_comb begin
        nx_d       = cur_q;
        fire_o     = 1'b0;
        load_val_o = '0;
        gap        = '0;
        gate_open  = !cts_en_i || cts_i;
        eof_any    = eof_i || cur_q.pend;

        case (cur_q.state)
            RS_IDLE: begin
                adv = start_i && gate_open;
                if (start_i && !gate_open) nx_d.state = RS_CTS;
            end
            RS_CTS:                          adv = gate_open;
            RS_UP2, RS_UP3, RS_DN2, RS_DN1:  adv = expire_i;
            RS_ON:                           adv = eof_any;
            default:                         adv = 1'b0;
        endcase

        if (cur_q.state inside {RS_CTS, RS_UP2, RS_UP3})
            nx_d.pend = cur_q.pend || eof_i;
        else
            nx_d.pend = 1'b0;

        for (int i = 0; i < NUM_STRB; i++) begin
            if (adv) begin
                fire_o = 1'b1;
                gap    = '0;
                case (nx_d.state)
                    RS_IDLE, RS_CTS: begin
                        nx_d.strb[0] = 1'b1;
                        nx_d.state   = RS_UP2;
                        gap          = gap_up12_i;
                    end
                    RS_UP2: begin
                        nx_d.strb[1] = 1'b1;
                        nx_d.state   = RS_UP3;
                        gap          = gap_up23_i;
                    end
                    RS_UP3: begin
                        nx_d.strb[2] = 1'b1;
                        nx_d.state   = RS_ON;
                    end
                    RS_ON: begin
                        nx_d.strb[2] = 1'b0;
                        nx_d.state   = RS_DN2;
                        gap          = gap_dn32_i;
                    end
                    RS_DN2: begin
                        nx_d.strb[1] = 1'b0;
                        nx_d.state   = RS_DN1;
                        gap          = gap_dn21_i;
                    end
                    RS_DN1: begin
                        nx_d.strb[0] = 1'b0;
                        nx_d.state   = RS_IDLE;
                    end
                    default: nx_d.state = RS_IDLE;
                endcase
                load_val_o = gap;
                adv = (gap == '0) && !(nx_d.state inside {RS_ON, RS_IDLE});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= RS_IDLE;
            cur_q.strb  <= '0;
            cur_q.pend  <= 1'b0;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign strb_o = cur_q.strb;
    assign busy_o = (cur_q.state != RS_IDLE);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state inside {RS_UP2, RS_UP3, RS_DN2, RS_DN1} && !expire_i)
            |=> $stable(cur_q.strb));

endmodule

// File: rtl/tx_ramp_seq.sv
module tx_ramp_seq #(
    parameter int unsigned GAP_W  = 4,
    parameter int unsigned DIV_LO = 20,
    parameter int unsigned DIV_HI = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             eof_i,
    input  logic             cts_en_i,
    input  logic             cts_i,
    input  logic             presc_sel_i,
    input  logic [GAP_W-1:0] gap_up12_i,
    input  logic [GAP_W-1:0] gap_up23_i,
    input  logic [GAP_W-1:0] gap_dn32_i,
    input  logic [GAP_W-1:0] gap_dn21_i,
    output logic             t1_o,
    output logic             t2_o,
    output logic             t3_o,
    output logic             busy_o
);
    import tx_ramp_pkg::*;

    logic                tick;
    logic                expire;
    logic                fire;
    logic [GAP_W-1:0]    load_val;
    logic [NUM_STRB-1:0] strb;

    tx_ramp_prescaler #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (presc_sel_i),
        .restart_i (fire),
        .tick_o    (tick)
    );

    tx_ramp_gapcnt #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (fire),
        .load_val_i (load_val),
        .tick_i     (tick),
        .expire_o   (expire)
    );

    tx_ramp_fsm #(
        .GAP_W (GAP_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .eof_i      (eof_i),
        .cts_en_i   (cts_en_i),
        .cts_i      (cts_i),
        .gap_up12_i (gap_up12_i),
        .gap_up23_i (gap_up23_i),
        .gap_dn32_i (gap_dn32_i),
        .gap_dn21_i (gap_dn21_i),
        .expire_i   (expire),
        .strb_o     (strb),
        .busy_o     (busy_o),
        .fire_o     (fire),
        .load_val_o (load_val)
    );

    assign t1_o = strb[0];
    assign t2_o = strb[1];
    assign t3_o = strb[2];

    // R11
    order_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t3_o |-> t2_o);

    // R11
    order_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t2_o |-> t1_o);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t1_o |-> busy_o);

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $fell(t1_o));

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!t1_o && cts_en_i && !cts_i) |=> !t1_o);

endmodule

// File: tb/tx_ramp_seq_tb.sv
module tx_ramp_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, eof_i, cts_en_i, cts_i, presc_sel_i;
    logic [3:0] gap_up12_i, gap_up23_i, gap_dn32_i, gap_dn21_i;
    logic       t1_o, t2_o, t3_o, busy_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tx_ramp_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .eof_i       (eof_i),
        .cts_en_i    (cts_en_i),
        .cts_i       (cts_i),
        .presc_sel_i (presc_sel_i),
        .gap_up12_i  (gap_up12_i),
        .gap_up23_i  (gap_up23_i),
        .gap_dn32_i  (gap_dn32_i),
        .gap_dn21_i  (gap_dn21_i),
        .t1_o        (t1_o),
        .t2_o        (t2_o),
        .t3_o        (t3_o),
        .busy_o      (busy_o)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_i = 1'b0;
        eof_i   = 1'b0;
        cts_i   = 1'b0;
    endtask

    task automatic run_seq(string tag, int u12, int u23, int d32, int d21,
                           bit sel, bit cen, int cts_rise, int eof_at,
                           int restart_at);
        int unit, r1e, r2e, r3e, f3e, f2e, f1e;
        int r1a, r2a, r3a, f3a, f2a, f1a;
        int busy_bad, order_bad, late_hi;
        bit p1, p2, p3;
        unit = sel ? 40 : 20;
        r1e  = cen ? ((cts_rise > 1) ? cts_rise : 1) : 1;
        r2e  = r1e + u12 * unit;
        r3e  = r2e + u23 * unit;
        f3e  = (eof_at > r3e) ? eof_at : r3e + 1;
        f2e  = f3e + d32 * unit;
        f1e  = f2e + d21 * unit;
        r1a = -1; r2a = -1; r3a = -1; f3a = -1; f2a = -1; f1a = -1;
        busy_bad = 0; order_bad = 0; late_hi = 0;
        p1 = 1'b0; p2 = 1'b0; p3 = 1'b0;
        gap_up12_i  = 4'(u12);
        gap_up23_i  = 4'(u23);
        gap_dn32_i  = 4'(d32);
        gap_dn21_i  = 4'(d21);
        presc_sel_i = sel;
        cts_en_i    = cen;
        for (int c = 0; c <= f1e + 12; c++) begin
            if (c > 0) begin
                if (t1_o && !p1 && r1a < 0) r1a = c;
                if (t2_o && !p2 && r2a < 0) r2a = c;
                if (t3_o && !p3 && r3a < 0) r3a = c;
                if (!t3_o && p3 && f3a < 0) f3a = c;
                if (!t2_o && p2 && f2a < 0) f2a = c;
                if (!t1_o && p1 && f1a < 0) f1a = c;
                if (busy_o != ((c >= 1) && (c < f1e))) busy_bad++;
                if ((t3_o && !t2_o) || (t2_o && !t1_o)) order_bad++;
                if (c > f1e && (t1_o || busy_o)) late_hi++;
                p1 = t1_o; p2 = t2_o; p3 = t3_o;
            end
            start_i = (c + 1 == 1) || (c + 1 == restart_at);
            eof_i   = (c + 1 == eof_at);
            cts_i   = (c + 1 >= cts_rise);
            @(negedge clk);
        end
        idle_inputs();
        check(cen ? "R6" : "R2", {tag, " t1 rise"}, r1a, r1e);
        check("R2", {tag, " t2 rise"}, r2a, r2e);
        check("R2", {tag, " t3 rise"}, r3a, r3e);
        check("R3", {tag, " t3 fall"}, f3a, f3e);
        check("R3", {tag, " t2 fall"}, f2a, f2e);
        check("R3", {tag, " t1 fall"}, f1a, f1e);
        check("R9", {tag, " busy mismatches"}, busy_bad, 0);
        check("R11", {tag, " order violations"}, order_bad, 0);
        check("R8", {tag, " activity after end"}, late_hi, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        idle_inputs();
        cts_en_i = 1'b0; presc_sel_i = 1'b0;
        gap_up12_i = '0; gap_up23_i = '0; gap_dn32_i = '0; gap_dn21_i = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "t1 after reset", int'(t1_o), 0);
        check("R1", "t2 after reset", int'(t2_o), 0);
        check("R1", "t3 after reset", int'(t3_o), 0);
        check("R1", "busy after reset", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_basic();
        run_seq("R2 basic", 2, 1, 3, 1, 1'b0, 1'b0, 1, 100, 0);
    endtask

    task automatic test_long_unit();
        run_seq("R4 long unit", 1, 2, 1, 2, 1'b1, 1'b0, 1, 200, 0);
        run_seq("R4 max gaps", 15, 15, 15, 15, 1'b1, 1'b0, 1, 1300, 0);
    endtask

    task automatic test_zero_gaps();
        run_seq("R5 all zero", 0, 0, 0, 0, 1'b0, 1'b0, 1, 10, 0);
        run_seq("R5 mixed zero", 0, 3, 0, 2, 1'b0, 1'b0, 1, 90, 0);
    endtask

    task automatic test_cts();
        run_seq("R6 cts wait", 1, 1, 1, 1, 1'b0, 1'b1, 15, 120, 0);
        run_seq("R6 cts already high", 1, 0, 0, 1, 1'b0, 1'b1, 1, 40, 0);
    endtask

    task automatic test_no_cts();
        run_seq("R7 gate off cts low", 1, 1, 2, 1, 1'b0, 1'b0, 100000, 70, 0);
    endtask

    task automatic test_restart();
        run_seq("R8 start during ramp", 2, 2, 2, 2, 1'b0, 1'b0, 1, 120, 30);
        run_seq("R8 start during fall", 1, 1, 2, 2, 1'b0, 1'b0, 1, 60, 75);
    endtask

    task automatic test_early_eof();
        run_seq("R10 eof in ramp-up", 2, 1, 1, 1, 1'b0, 1'b0, 1, 5, 0);
        run_seq("R10 eof in cts wait", 1, 1, 1, 1, 1'b0, 1'b1, 20, 3, 0);
        run_seq("R10 eof at t3 rise", 1, 1, 1, 1, 1'b0, 1'b0, 1, 41, 0);
    endtask

    task automatic test_idle_eof();
        eof_i = 1'b1;
        @(negedge clk);
        eof_i = 1'b0;
        @(negedge clk);
        check("R10", "busy after idle eof", int'(busy_o), 0);
        run_seq("R10 idle eof ignored", 1, 1, 1, 1, 1'b0, 1'b0, 1, 80, 0);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_long_unit();
        test_zero_gaps();
        test_cts();
        test_no_cts();
        test_restart();
        test_early_eof();
        test_idle_eof();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule